// File: doc/BRIEF.md
# Table-Based Grid Phase-Locked Loop

This block follows the phase of one line-to-neutral grid voltage. A stream of signed voltage samples comes in at 25 kS/s. For each accepted sample the block produces a phase index into a full-cycle sine table, the table sine at that index and the frequency word in use. The modulator uses the phase and sine as its synchronising reference. The frequency word drives frequency supervision. A converter needs one instance per phase, so it uses three.

Inside the block, a phase detector multiplies each sample by the table cosine at the current phase. A proportional-integral filter with programmable gains turns that product into a correction. The integrator saturates. The correction is added to the nominal 50 Hz increment and the sum steps a 32-bit phase accumulator. The block also reports a lock flag. It raises an alarm whenever the tracked frequency leaves the band from 49.5 Hz to 50.5 Hz.

Both streams use valid/ready. A sample is taken in on any cycle where `s_valid` and `s_ready` are both high. The result of that sample is held in one output register until the consumer takes it. `s_ready` is high when that register is empty or is being drained in the same cycle. A stalled consumer therefore stalls the sample stream without losing data. A sample waits on the input, with its data held stable, for as long as `s_ready` is low.

Top module: `grid_pll`

## Requirements
- R1: While `m_valid` is high and `m_ready` is low, `s_ready` is low and `m_phase`, `m_sine` and `m_freq` hold their values. When the output register is empty, `s_ready` is high.
- R2: `m_phase` is bits [31:21] of the 32-bit phase accumulator as it stood before the sample was accepted. Each accepted sample then adds `m_freq` to the accumulator. When both gains are zero, `m_freq` is 8589935, and the k-th sample after reset (counting from k=0) reports phase ((k*8589935) mod 2^32) >> 21.
- R3: The table holds 2048 entries. For index i, let h = i mod 1024. The entry is (h*(1024-h)) >> 4, negated when i >= 1024. `m_sine` is the entry at `m_phase`. The detector cosine is the entry at (`m_phase` + 512) mod 2048.
- R4: The phase error is (sample * cosine) shifted right arithmetically by 14, so negative values are rounded toward minus infinity.
- R5: The integrator becomes integ + ((err*ki) >>> 8). The proportional term is (err*kp) >>> 4. `m_freq` is the low 32 bits of 8589935 + proportional term + new integrator.
- R6: The integrator stays within ±262144 and saturates at these limits.
- R7: `freq_alarm` is updated with each accepted sample. It is high when the frequency word is below 8504036 (under 49.5 Hz) or above 8675833 (over 50.5 Hz).
- R8: `locked` rises on the 16th consecutive accepted sample whose |proportional term + new integrator| is below `lock_thr`. It falls on the first accepted sample that does not meet this condition.
- R9: Only an accepted sample changes the accumulator, the integrator, the lock count, `locked`, `freq_alarm` and `m_freq`. A consumed output with no new sample clears `m_valid`.
- R10: After reset, `m_valid`, `locked`, `freq_alarm`, `m_phase` and the accumulator are zero, and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready |
| s_sample | input | 16 | Signed voltage sample |
| m_valid | output | 1 | Result stream valid |
| m_ready | input | 1 | Result stream ready |
| m_phase | output | 11 | Table phase index of the accepted sample |
| m_sine | output | 16 | Signed table sine at `m_phase` |
| m_freq | output | 32 | Frequency word applied after the sample |
| kp | input | 16 | Proportional gain (unsigned) |
| ki | input | 16 | Integral gain (unsigned) |
| lock_thr | input | 32 | Lock threshold on the loop correction |
| locked | output | 1 | Lock flag |
| freq_alarm | output | 1 | Out-of-band frequency alarm |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, an 11-bit table index, an integrator limit of 2^18 and a lock run of 16. At 500 samples per nominal cycle, a zero-gain run of about 520 samples sweeps the whole table. An integral gain of 255, fed samples that keep the error one-signed, reaches either integrator limit within about 20 samples. Because 2^18 is about three times the half-band of roughly 85898, both edges of the alarm band can be crossed. The short lock run lets the bench see the flag rise exactly at the 16th quiet sample and fall on the next loud one.

// File: rtl/grid_pll_pkg.sv
package grid_pll_pkg;

  localparam int RND_NEAR  = 0;
  localparam int RND_UP    = 1;
  localparam int RND_DOWN  = 2;

  // Accumulator increment per sample for a frequency given in millihertz.
  function automatic longint unsigned hz_to_word(input longint unsigned mhz,
                                                 input longint unsigned fs_hz,
                                                 input int aw,
                                                 input int mode);
    longint unsigned num;
    longint unsigned den;
    num = (64'd1 << aw) * mhz;
    den = fs_hz * 64'd1000;
    case (mode)
      RND_NEAR: return (num + den / 2) / den;
      RND_UP:   return (num + den - 1) / den;
      default:  return num / den;
    endcase
  endfunction

  // Symmetric clamp used by the loop integrator.
  function automatic logic signed [63:0] clamp_sym(input logic signed [63:0] v,
                                                   input logic signed [63:0] lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

endpackage

// File: rtl/grid_pll_wave.sv
// Computed full-cycle wave table: a parabola per half cycle, several read ports.
module grid_pll_wave #(
  parameter int TW    = 11,
  parameter int TBW   = 16,
  parameter int NPORT = 2
) (
  input  logic [NPORT-1:0][TW-1:0]  idx,
  output logic [NPORT-1:0][TBW-1:0] val
);
  localparam int PW   = 2 * TW;
  localparam int HALF = 2 ** (TW - 1);
  localparam int SH   = 2 * TW - TBW - 2;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [PW-1:0] h;
    logic [PW-1:0] mag;
    always_comb begin
      h   = PW'(idx[p][TW-2:0]);
      mag = (h * (PW'(HALF) - h)) >> SH;
      val[p] = idx[p][TW-1] ? TBW'(-mag) : TBW'(mag);
    end
  end
endmodule

// File: rtl/grid_pll_detect.sv
// Multiplying phase detector: sample times reference cosine, rescaled.
module grid_pll_detect #(
  parameter int SW  = 16,
  parameter int TBW = 16
) (
  input  logic signed [SW-1:0]     smp,
  input  logic signed [TBW-1:0]    ref_c,
  output logic signed [SW+TBW-1:0] err
);
  localparam int PW = SW + TBW;
  logic signed [PW-1:0] smp_x;
  logic signed [PW-1:0] ref_x;
  logic signed [PW-1:0] prod;

  assign smp_x = {{TBW{smp[SW-1]}}, smp};
  assign ref_x = {{SW{ref_c[TBW-1]}}, ref_c};
  assign prod  = smp_x * ref_x;
  assign err   = prod >>> (TBW - 2);
endmodule

// File: rtl/grid_pll_loopfilt.sv
// Proportional-integral loop filter with a saturating integrator.
module grid_pll_loopfilt
  import grid_pll_pkg::*;
#(
  parameter int     EW    = 32,
  parameter int     GW    = 16,
  parameter int     KP_SH = 4,
  parameter int     KI_SH = 8,
  parameter int     IW    = 32,
  parameter longint ILIM  = 262144
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic signed [EW-1:0] err,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  output logic signed [IW-1:0] integ_q,
  output logic signed [63:0]   corr
);
  logic signed [63:0] e64, kp64, ki64, i64;
  logic signed [63:0] prop, i_step, integ_n;

  assign e64  = {{(64-EW){err[EW-1]}}, err};
  assign kp64 = {{(64-GW){1'b0}}, kp};
  assign ki64 = {{(64-GW){1'b0}}, ki};
  assign i64  = {{(64-IW){integ_q[IW-1]}}, integ_q};

  assign prop    = (e64 * kp64) >>> KP_SH;
  assign i_step  = (e64 * ki64) >>> KI_SH;
  assign integ_n = clamp_sym(i64 + i_step, 64'(ILIM));
  assign corr    = prop + integ_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   integ_q <= '0;
    else if (adv) integ_q <= IW'(integ_n);
  end
endmodule

// File: rtl/grid_pll_nco.sv
// Phase accumulator stepped by nominal increment plus loop correction.
module grid_pll_nco #(
  parameter int            AW  = 32,
  parameter int            TW  = 11,
  parameter logic [AW-1:0] NOM = AW'(8589935),
  parameter logic [AW-1:0] LO  = AW'(8504036),
  parameter logic [AW-1:0] HI  = AW'(8675833)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic signed [63:0] corr,
  output logic [TW-1:0]      phase,
  output logic [AW-1:0]      inc,
  output logic               alarm_n
);
  logic [AW-1:0]      acc;
  logic signed [63:0] sum;

  assign sum     = $signed({{(64-AW){1'b0}}, NOM}) + corr;
  assign inc     = sum[AW-1:0];
  assign phase   = acc[AW-1 -: TW];
  assign alarm_n = (inc < LO) || (inc > HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (adv) acc <= acc + inc;
  end
endmodule

// File: rtl/grid_pll.sv
module grid_pll
  import grid_pll_pkg::*;
#(
  parameter int          SW         = 16,
  parameter int          AW         = 32,
  parameter int          TW         = 11,
  parameter int          TBW        = 16,
  parameter int          GW         = 16,
  parameter int          LTW        = 32,
  parameter int          KP_SH      = 4,
  parameter int          KI_SH      = 8,
  parameter int          IW         = 32,
  parameter longint      ILIM       = 262144,
  parameter int          LOCK_N     = 16,
  parameter int unsigned FS_HZ      = 25000,
  parameter int unsigned F_NOM_MHZ  = 50000,
  parameter int unsigned F_BAND_MHZ = 500
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s_valid,
  output logic           s_ready,
  input  logic [SW-1:0]  s_sample,
  output logic           m_valid,
  input  logic           m_ready,
  output logic [TW-1:0]  m_phase,
  output logic [TBW-1:0] m_sine,
  output logic [AW-1:0]  m_freq,
  input  logic [GW-1:0]  kp,
  input  logic [GW-1:0]  ki,
  input  logic [LTW-1:0] lock_thr,
  output logic           locked,
  output logic           freq_alarm
);
  localparam logic [AW-1:0] NOM_INC  = AW'(hz_to_word(64'(F_NOM_MHZ), 64'(FS_HZ), AW, RND_NEAR));
  localparam logic [AW-1:0] ALARM_LO = AW'(hz_to_word(64'(F_NOM_MHZ - F_BAND_MHZ), 64'(FS_HZ), AW, RND_UP));
  localparam logic [AW-1:0] ALARM_HI = AW'(hz_to_word(64'(F_NOM_MHZ + F_BAND_MHZ), 64'(FS_HZ), AW, RND_DOWN));
  localparam int            QTR      = 2 ** (TW - 2);
  localparam int            CW       = $clog2(LOCK_N + 1);
  localparam int            EW       = SW + TBW;

  logic                       accept;
  logic [TW-1:0]              ph_now;
  logic [1:0][TW-1:0]         wv_idx;
  logic [1:0][TBW-1:0]        wv_val;
  logic signed [EW-1:0]       err;
  logic signed [63:0]         corr;
  logic signed [IW-1:0]       integ_q;
  logic [AW-1:0]              inc;
  logic                       alarm_n;
  logic [63:0]                abs_corr;
  logic                       quiet;
  logic [CW-1:0]              cnt_q, cnt_n;

  assign s_ready = !m_valid || m_ready;
  assign accept  = s_valid && s_ready;

  // port 0: sine at current phase, port 1: cosine (quarter cycle ahead)
  assign wv_idx[0] = ph_now;
  assign wv_idx[1] = ph_now + TW'(QTR);

  grid_pll_wave #(.TW(TW), .TBW(TBW), .NPORT(2)) u_wave (
    .idx (wv_idx),
    .val (wv_val)
  );

  grid_pll_detect #(.SW(SW), .TBW(TBW)) u_det (
    .smp   ($signed(s_sample)),
    .ref_c ($signed(wv_val[1])),
    .err   (err)
  );

  grid_pll_loopfilt #(
    .EW(EW), .GW(GW), .KP_SH(KP_SH), .KI_SH(KI_SH), .IW(IW), .ILIM(ILIM)
  ) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (accept),
    .err     (err),
    .kp      (kp),
    .ki      (ki),
    .integ_q (integ_q),
    .corr    (corr)
  );

  grid_pll_nco #(
    .AW(AW), .TW(TW), .NOM(NOM_INC), .LO(ALARM_LO), .HI(ALARM_HI)
  ) u_nco (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (accept),
    .corr    (corr),
    .phase   (ph_now),
    .inc     (inc),
    .alarm_n (alarm_n)
  );

  // lock qualification on the size of the loop correction
  assign abs_corr = corr[63] ? 64'(-corr) : 64'(corr);
  assign quiet    = abs_corr < {{(64-LTW){1'b0}}, lock_thr};

  always_comb begin
    if (!quiet)                     cnt_n = '0;
    else if (cnt_q == CW'(LOCK_N))  cnt_n = cnt_q;
    else                            cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      locked     <= 1'b0;
      freq_alarm <= 1'b0;
    end else if (accept) begin
      cnt_q      <= cnt_n;
      locked     <= (cnt_n == CW'(LOCK_N));
      freq_alarm <= alarm_n;
    end
  end

  // single-entry result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_phase <= '0;
      m_sine  <= '0;
      m_freq  <= '0;
    end else if (accept) begin
      m_valid <= 1'b1;
      m_phase <= ph_now;
      m_sine  <= wv_val[0];
      m_freq  <= inc;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/grid_pll_chk.sv
module grid_pll_chk #(
  parameter int            TW   = 11,
  parameter int            TBW  = 16,
  parameter int            AW   = 32,
  parameter int            IW   = 32,
  parameter longint        ILIM = 262144,
  parameter logic [AW-1:0] LO   = AW'(8504036),
  parameter logic [AW-1:0] HI   = AW'(8675833)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 s_valid,
  input logic                 s_ready,
  input logic                 m_valid,
  input logic                 m_ready,
  input logic [TW-1:0]        m_phase,
  input logic [TBW-1:0]       m_sine,
  input logic [AW-1:0]        m_freq,
  input logic                 locked,
  input logic                 freq_alarm,
  input logic signed [IW-1:0] integ
);
  localparam logic signed [IW-1:0] LIM_P = IW'(ILIM);
  localparam logic signed [IW-1:0] LIM_N = -LIM_P;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_phase) && $stable(m_sine) && $stable(m_freq)));

  assert_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(s_valid));

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !s_valid) |=> !m_valid);

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=> ($stable(locked) && $stable(freq_alarm) && $stable(m_freq)));

  assert_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (integ <= LIM_P) && (integ >= LIM_N));

  assert_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (freq_alarm == ((m_freq < LO) || (m_freq > HI))));

  assert_lockrise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(s_valid && s_ready));
endmodule

bind grid_pll grid_pll_chk #(
  .TW(TW), .TBW(TBW), .AW(AW), .IW(IW), .ILIM(ILIM), .LO(ALARM_LO), .HI(ALARM_HI)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .m_valid    (m_valid),
  .m_ready    (m_ready),
  .m_phase    (m_phase),
  .m_sine     (m_sine),
  .m_freq     (m_freq),
  .locked     (locked),
  .freq_alarm (freq_alarm),
  .integ      (integ_q)
);

// File: tb/grid_pll_tb.sv
`timescale 1ns/1ps
module grid_pll_tb;
  localparam longint NOM  = 8589935;
  localparam longint LO   = 8504036;
  localparam longint HI   = 8675833;
  localparam longint ILIM = 262144;

  typedef struct packed {
    logic [10:0] ph;
    logic [15:0] sn;
    logic [31:0] fr;
    logic        lk;
    logic        al;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_sample = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [10:0] m_phase;
  logic [15:0] m_sine;
  logic [31:0] m_freq;
  logic [15:0] kp = '0;
  logic [15:0] ki = '0;
  logic [31:0] lock_thr = '0;
  logic        locked;
  logic        freq_alarm;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  item_t exp_q[$];

  logic [31:0] mdl_acc;
  longint      mdl_int;
  int          mdl_cnt;

  always #2 clk = ~clk;

  grid_pll u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_sample(s_sample),
    .m_valid(m_valid), .m_ready(m_ready), .m_phase(m_phase), .m_sine(m_sine),
    .m_freq(m_freq), .kp(kp), .ki(ki), .lock_thr(lock_thr), .locked(locked),
    .freq_alarm(freq_alarm)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint wave(input int idx);
    int     h;
    longint y;
    h = idx % 1024;
    y = (longint'(h) * longint'(1024 - h)) >>> 4;
    return (idx >= 1024) ? -y : y;
  endfunction

  function automatic logic [15:0] cos_now();
    return 16'(wave((int'(mdl_acc[31:21]) + 512) % 2048));
  endfunction

  task automatic model_step(input logic [15:0] smp, output item_t it);
    int          ph;
    longint      c, e, ni, prop, corr, ac;
    logic [31:0] inc;
    ph   = int'(mdl_acc[31:21]);
    c    = wave((ph + 512) % 2048);
    e    = (longint'($signed(smp)) * c) >>> 14;
    ni   = mdl_int + ((e * longint'(ki)) >>> 8);
    if (ni > ILIM)  ni = ILIM;
    if (ni < -ILIM) ni = -ILIM;
    prop = (e * longint'(kp)) >>> 4;
    corr = prop + ni;
    inc  = 32'(NOM + corr);
    ac   = (corr < 0) ? -corr : corr;
    if (ac < longint'(lock_thr)) mdl_cnt = (mdl_cnt == 16) ? 16 : mdl_cnt + 1;
    else                         mdl_cnt = 0;
    it.ph = 11'(ph);
    it.sn = 16'(wave(ph));
    it.fr = inc;
    it.lk = (mdl_cnt == 16);
    it.al = (longint'(inc) < LO) || (longint'(inc) > HI);
    mdl_int = ni;
    mdl_acc = mdl_acc + inc;
  endtask

  // driver: offers one sample, records the expected result on acceptance
  task automatic send(input logic [15:0] smp);
    item_t it;
    @(negedge clk);
    s_valid  = 1'b1;
    s_sample = smp;
    @(posedge clk);
    while (!s_ready) @(posedge clk);
    model_step(smp, it);
    exp_q.push_back(it);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  // monitor: compares each consumed result with the scoreboard head
  always @(posedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected output", 1, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(m_phase == e.ph, "R2 phase", longint'(m_phase), longint'(e.ph));
        check(m_sine == e.sn, "R3 sine", longint'($signed(m_sine)), longint'($signed(e.sn)));
        check(m_freq == e.fr, "R5 freq word", longint'(m_freq), longint'(e.fr));
        check(locked == e.lk, "R8 lock", longint'(locked), longint'(e.lk));
        check(freq_alarm == e.al, "R7 alarm", longint'(freq_alarm), longint'(e.al));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    mdl_acc = '0;
    mdl_int = 0;
    mdl_cnt = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) check(1'b0, "R1 results left unconsumed", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    done = 1'b1;
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] f_hold;
    logic [10:0] p_hold;
    logic        l_hold, a_hold;
    longint      ep;

    do_reset();
    // R10: reset state
    check(m_valid == 1'b0, "R10 m_valid", longint'(m_valid), 0);
    check(locked == 1'b0, "R10 locked", longint'(locked), 0);
    check(freq_alarm == 1'b0, "R10 alarm", longint'(freq_alarm), 0);
    check(s_ready == 1'b1, "R10 s_ready", longint'(s_ready), 1);
    check(m_phase == 11'd0, "R10 phase", longint'(m_phase), 0);

    // R2/R3: zero gains, sweep a full cycle with varied samples
    for (int k = 0; k < 520; k++) send(16'((k * 7919) % 30000 - 15000));
    ep = ((longint'(519) * NOM) & 64'hFFFFFFFF) >> 21;
    check(longint'(m_phase) == ep, "R2 nominal phase after 520 samples", longint'(m_phase), ep);
    check(longint'(m_freq) == NOM, "R2 nominal word", longint'(m_freq), NOM);

    // R9: idle cycles change nothing
    f_hold = m_freq; l_hold = locked; a_hold = freq_alarm;
    repeat (10) @(negedge clk);
    check(m_valid == 1'b0, "R9 drained output", longint'(m_valid), 0);
    check(m_freq == f_hold && locked == l_hold && freq_alarm == a_hold,
          "R9 state stable while idle", longint'(m_freq), longint'(f_hold));
    send(16'sd1234);
    ep = ((longint'(520) * NOM) & 64'hFFFFFFFF) >> 21;
    check(longint'(m_phase) == ep, "R9 accumulator held while idle", longint'(m_phase), ep);

    // R1: back-pressure
    @(negedge clk);
    m_ready = 1'b0;
    send(16'sd500);
    p_hold = m_phase; f_hold = m_freq;
    fork
      send(-16'sd800);
      begin
        repeat (4) @(negedge clk);
        check(s_ready == 1'b0, "R1 s_ready low when full", longint'(s_ready), 0);
        check(m_valid == 1'b1, "R1 m_valid held", longint'(m_valid), 1);
        check(m_phase == p_hold && m_freq == f_hold, "R1 output stable under stall",
              longint'(m_phase), longint'(p_hold));
        m_ready = 1'b1;
      end
    join
    repeat (3) @(negedge clk);

    // R4: detector arithmetic
    do_reset();
    kp = 16'd16; ki = 16'd0;
    send(16'sd1000);
    check(longint'(m_freq) == NOM + 1000, "R4 error scale", longint'(m_freq), NOM + 1000);
    send(-16'sd7);
    check(longint'(m_freq) == NOM - 7, "R4 arithmetic shift floors", longint'(m_freq), NOM - 7);

    // R6/R7: drive integrator to upper limit
    do_reset();
    kp = 16'd16; ki = 16'd255;
    for (int k = 0; k < 60; k++) send(cos_now());
    check(freq_alarm == 1'b1, "R7 alarm above band", longint'(freq_alarm), 1);
    check(longint'(m_freq) >= NOM + ILIM && longint'(m_freq) <= NOM + ILIM + 16384,
          "R6 integrator saturated high", longint'(m_freq), NOM + ILIM);

    // R6/R7: lower limit
    do_reset();
    for (int k = 0; k < 60; k++) send(16'(-$signed(cos_now())));
    check(freq_alarm == 1'b1, "R7 alarm below band", longint'(freq_alarm), 1);
    check(longint'(m_freq) <= NOM - ILIM && longint'(m_freq) >= NOM - ILIM - 16384,
          "R6 integrator saturated low", longint'(m_freq), NOM - ILIM);

    // R8: lock after 16 quiet samples, drop on a loud one
    do_reset();
    kp = 16'd16; ki = 16'd0; lock_thr = 32'd100;
    for (int k = 0; k < 15; k++) send(16'sd0);
    check(locked == 1'b0, "R8 not locked after 15", longint'(locked), 0);
    send(16'sd0);
    check(locked == 1'b1, "R8 locked at 16", longint'(locked), 1);
    check(freq_alarm == 1'b0, "R7 no alarm at nominal", longint'(freq_alarm), 0);
    send(16'sd20000);
    check(locked == 1'b0, "R8 lock dropped", longint'(locked), 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule